// File: doc/BRIEF.md
# Synchronous Burst SRAM with Address Sequencer

This block models a single-ported synchronous static RAM with a flow-through read path and a built-in four-beat burst sequencer. A burst begins when either of two active-low address strobes, one for a processor and one for a cache controller, is sampled low on a rising clock edge. That edge captures the address, the three chip selects and the burst-order input. From then on, an active-low advance input steps the two low address bits through one of two wrap orders. The upper address bits stay where they were loaded.

Reads are flow-through. In the cycle after the load, the array word at the current burst address appears combinationally on the data output, and the word changes in each cycle after an advance. A first beat therefore takes two cycles and each following beat takes one. Writes are synchronous. Each edge writes the current burst address using either four byte-lane enables, qualified by a byte-write enable, or a global write that covers all lanes. The output enable acts without a clock.

The sequencer has a two-state controller. `ST_DESEL` means no burst is selected. `ST_ACTIVE` means a selected burst is open. A strobe load with every chip select active is transition T_SELECT (`ST_DESEL` to `ST_ACTIVE`) or T_RELOAD (`ST_ACTIVE` to `ST_ACTIVE`, restarting the count). A strobe load with any chip select inactive is T_DESELECT, which leads to `ST_DESEL`. With no load, the controller stays in its state (T_HOLD), and in `ST_ACTIVE` it steps the beat count when advance is low.

Top module: `burst_sram`

## Requirements
- R1: While reset is asserted and after it is released, the block is in `ST_DESEL`, `dout_en` is 0 and `dout` is all zeros.
- R2: A low `strobe_ctl_n`, or a low `strobe_cpu_n` together with a low `sel_pipe_n`, loads a burst on the rising edge. The burst is selected only if `sel_pipe_n`=0, `sel_hi`=1 and `sel_lo_n`=0.
- R3: A `strobe_cpu_n` load while `sel_pipe_n` is high is ignored, and an open burst continues unchanged. A `strobe_ctl_n` load with any chip select inactive deselects the block, so `dout_en` becomes 0.
- R4: With `mode_intlv`=0 latched at load, beat k (k counts advances mod 4) reads the address whose low two bits are (start + k) mod 4.
- R5: With `mode_intlv`=1 latched at load, beat k reads the address whose low two bits are start XOR k. For example, start 2 gives 2, 3, 0, 1.
- R6: While no load occurs, the address bits above bit 1 never change. With `adv_n` high, the whole burst address holds.
- R7: With `byte_we_n`=0, each lane i whose `lane_we_n[i]`=0 writes `din[8i+7:8i]` to the current burst address on the rising edge, and the other lanes are kept. With `byte_we_n`=1, the lane enables have no effect.
- R8: With `all_we_n`=0, all four bytes are written on the rising edge, whatever the lane enables are.
- R9: `dout_en` is 1 exactly when `oe_n`=0, a burst is selected and no write enable is asserted, and it follows `oe_n` without a clock edge. When `dout_en`=0, `dout` is zero.
- R10: The word at the loaded address is presented in the cycle right after the load edge, and each advance presents the next beat in the following cycle (2-1-1-1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of the sequencer |
| addr | input | ADDR_W | Word address, captured on a load |
| sel_pipe_n | input | 1 | Active-low pipelining chip select; also gates the processor strobe |
| sel_hi | input | 1 | Active-high depth-expansion chip select |
| sel_lo_n | input | 1 | Active-low depth-expansion chip select |
| strobe_cpu_n | input | 1 | Active-low processor address strobe |
| strobe_ctl_n | input | 1 | Active-low controller address strobe |
| adv_n | input | 1 | Active-low burst advance |
| mode_intlv | input | 1 | Burst order: 1 interleaved, 0 linear |
| lane_we_n | input | 4 | Active-low per-byte write enables |
| byte_we_n | input | 1 | Active-low qualifier for the lane enables |
| all_we_n | input | 1 | Active-low global write of all lanes |
| oe_n | input | 1 | Active-low output enable, asynchronous |
| din | input | 32 | Write data |
| dout | output | 32 | Flow-through read data, zero when not driven |
| dout_en | output | 1 | High while the read data is driven |

## Verification
On every cycle, the in-RTL assertions check several properties. The processor strobe is gated by the pipelining select. A controller load with a bad select closes the burst. The upper address bits and the held count stay fixed, and an advance steps the count by one mod 4. A load presents the captured address. The output drive is never on while output enable is high, while deselected or while a write is asserted. The wrap orders themselves and the byte-lane merge can only be seen in the bench's scenarios, which compare the read data against a reference array: directed linear and interleaved bursts, partial-lane writes, and a long mixed random run.

// File: rtl/burst_sram_pkg.sv
package burst_sram_pkg;

    typedef enum logic [0:0] {
        ST_DESEL  = 1'b0,
        ST_ACTIVE = 1'b1
    } bstate_e;

    localparam int BEAT_W = 2;

    // low address bits of a beat: XOR order or modulo-4 add order
    function automatic logic [BEAT_W-1:0] beat_offset(
        input logic [BEAT_W-1:0] start,
        input logic [BEAT_W-1:0] count,
        input logic              intlv
    );
        logic [BEAT_W-1:0] res;
        if (intlv) res = start ^ count;
        else       res = start + count;
        return res;
    endfunction

endpackage

// File: rtl/burst_ctrl.sv
module burst_ctrl
    import burst_sram_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic sel_ok,
    output logic active
);
    bstate_e state_q, state_d;

    // next-state logic and state register
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_DESEL: begin
                if (load && sel_ok) state_d = ST_ACTIVE;      // T_SELECT
            end
            ST_ACTIVE: begin
                if (load && !sel_ok) state_d = ST_DESEL;      // T_DESELECT
                else                 state_d = ST_ACTIVE;     // T_RELOAD / T_HOLD
            end
            default: state_d = ST_DESEL;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_DESEL;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        unique case (state_q)
            ST_ACTIVE: active = 1'b1;
            default:   active = 1'b0;
        endcase
    end

    // R1: reset leaves the controller deselected
    a_r1_reset_desel: assert property (@(posedge clk)
        !rst_n |=> !active);

    // R3: a load without full select always closes the burst
    a_r3_bad_sel_closes: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !sel_ok) |=> !active);
endmodule

// File: rtl/burst_seq.sv
module burst_seq
    import burst_sram_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              step,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              intlv_in,
    output logic [ADDR_W-1:0] cur_addr
);
    localparam int UP_W = ADDR_W - BEAT_W;

    logic [UP_W-1:0]   upper_q;
    logic [BEAT_W-1:0] start_q;
    logic [BEAT_W-1:0] cnt_q;
    logic              intlv_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            upper_q <= '0;
            start_q <= '0;
            cnt_q   <= '0;
            intlv_q <= 1'b0;
        end else if (load) begin
            upper_q <= addr_in[ADDR_W-1:BEAT_W];
            start_q <= addr_in[BEAT_W-1:0];
            cnt_q   <= '0;
            intlv_q <= intlv_in;
        end else if (step) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign cur_addr = {upper_q, beat_offset(start_q, cnt_q, intlv_q)};

    // R6: upper bits fixed without a load
    a_r6_upper_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(cur_addr[ADDR_W-1:BEAT_W]));

    // R6: no advance, no movement
    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !step) |=> $stable(cur_addr));

    // R4/R5 share the count: an advance steps it by one mod 4
    a_r4_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && step) |=> (cnt_q == $past(cnt_q) + 2'd1));

    // R10: first beat addresses the captured word
    a_r10_first_beat: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cur_addr == $past(addr_in)));
endmodule

// File: rtl/lane_array.sv
module lane_array #(
    parameter int ADDR_W = 10,
    parameter int LANES  = 4,
    parameter int LANE_W = 8
) (
    input  logic                      clk,
    input  logic [ADDR_W-1:0]         addr,
    input  logic [LANES-1:0]          lane_wr,
    input  logic [LANES*LANE_W-1:0]   wdata,
    output logic [LANES*LANE_W-1:0]   rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] mem [DEPTH];

        always_ff @(posedge clk) begin
            if (lane_wr[g]) mem[addr] <= wdata[g*LANE_W +: LANE_W];
        end

        assign rdata[g*LANE_W +: LANE_W] = mem[addr];
    end
endmodule

// File: rtl/burst_sram.sv
module burst_sram
    import burst_sram_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int LANES  = 4,
    parameter int LANE_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ADDR_W-1:0]       addr,
    input  logic                    sel_pipe_n,
    input  logic                    sel_hi,
    input  logic                    sel_lo_n,
    input  logic                    strobe_cpu_n,
    input  logic                    strobe_ctl_n,
    input  logic                    adv_n,
    input  logic                    mode_intlv,
    input  logic [LANES-1:0]        lane_we_n,
    input  logic                    byte_we_n,
    input  logic                    all_we_n,
    input  logic                    oe_n,
    input  logic [LANES*LANE_W-1:0] din,
    output logic [LANES*LANE_W-1:0] dout,
    output logic                    dout_en
);
    localparam int DATA_W = LANES * LANE_W;

    logic              load_cpu, load_ctl, load, sel_ok, active, step;
    logic [ADDR_W-1:0] cur_addr;
    logic [LANES-1:0]  lane_req, lane_wr;
    logic              wr_req;
    logic [DATA_W-1:0] rdata;

    // processor strobe is gated by the pipelining select
    assign load_cpu = !strobe_cpu_n && !sel_pipe_n;
    assign load_ctl = !strobe_ctl_n;
    assign load     = load_cpu || load_ctl;
    assign sel_ok   = !sel_pipe_n && sel_hi && !sel_lo_n;
    assign step     = active && !adv_n;

    burst_ctrl u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (load),
        .sel_ok (sel_ok),
        .active (active)
    );

    burst_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .step     (step),
        .addr_in  (addr),
        .intlv_in (mode_intlv),
        .cur_addr (cur_addr)
    );

    // lane write requests: global write or qualified byte lanes
    for (genvar g = 0; g < LANES; g++) begin : g_we
        assign lane_req[g] = !all_we_n || (!byte_we_n && !lane_we_n[g]);
    end
    assign wr_req  = |lane_req;
    assign lane_wr = active ? lane_req : '0;

    lane_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
        .clk     (clk),
        .addr    (cur_addr),
        .lane_wr (lane_wr),
        .wdata   (din),
        .rdata   (rdata)
    );

    // flow-through read, asynchronous output enable
    assign dout_en = !oe_n && active && !wr_req;
    assign dout    = dout_en ? rdata : '0;

    // R3: gated processor strobe leaves an open burst open
    a_r3_cpu_gated: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !strobe_cpu_n && sel_pipe_n && strobe_ctl_n) |=> active);

    // R9: no drive with output enable high
    a_r9_oe_off: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> !dout_en);

    // R9: no drive while a write enable is asserted
    a_r9_write_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!all_we_n || (!byte_we_n && !(&lane_we_n))) |-> !dout_en);

    // R1/R9: output bus quiet when not driven
    a_r9_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !dout_en |-> (dout == '0));

    // R7: lane enables without qualifier write nothing
    a_r7_no_qual: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_we_n && all_we_n) |-> (lane_wr == '0));
endmodule

// File: tb/burst_sram_bench.sv
`timescale 1ns/1ps
module burst_sram_bench;
    localparam int ADDR_W = 10;
    localparam int REF_N  = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [ADDR_W-1:0] addr;
    logic        sel_pipe_n, sel_hi, sel_lo_n, strobe_cpu_n, strobe_ctl_n;
    logic        adv_n, mode_intlv, byte_we_n, all_we_n, oe_n;
    logic [3:0]  lane_we_n;
    logic [31:0] din, dout;
    logic        dout_en;

    int tests = 0;
    int fails = 0;
    bit done  = 0;

    // reference state
    logic [31:0] ref_mem [REF_N];
    bit          m_sel;
    logic [5:0]  m_base;
    logic [1:0]  m_cnt;
    bit          m_intlv;

    always #2.5 clk = ~clk;

    burst_sram #(.ADDR_W(ADDR_W)) u_burst_sram (
        .clk(clk), .rst_n(rst_n), .addr(addr),
        .sel_pipe_n(sel_pipe_n), .sel_hi(sel_hi), .sel_lo_n(sel_lo_n),
        .strobe_cpu_n(strobe_cpu_n), .strobe_ctl_n(strobe_ctl_n),
        .adv_n(adv_n), .mode_intlv(mode_intlv), .lane_we_n(lane_we_n),
        .byte_we_n(byte_we_n), .all_we_n(all_we_n), .oe_n(oe_n),
        .din(din), .dout(dout), .dout_en(dout_en)
    );

    function automatic logic [31:0] pat(input int a);
        return 32'hA5A5_0000 | a;
    endfunction

    function automatic logic [5:0] cur_ref();
        logic [1:0] lo;
        lo = m_intlv ? (m_base[1:0] ^ m_cnt) : (m_base[1:0] + m_cnt);
        return {m_base[5:2], lo};
    endfunction

    function automatic bit wr_now();
        return !all_we_n || (!byte_we_n && lane_we_n != 4'hF);
    endfunction

    task automatic check(input bit ok, input string tag,
                         input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle();
        addr = '0; sel_pipe_n = 0; sel_hi = 1; sel_lo_n = 0;
        strobe_cpu_n = 1; strobe_ctl_n = 1; adv_n = 1; mode_intlv = 0;
        lane_we_n = 4'hF; byte_we_n = 1; all_we_n = 1; oe_n = 0; din = '0;
    endtask

    // compare outputs with the reference in the current cycle
    task automatic model_check(input string tag);
        bit exp_en;
        logic [31:0] exp_d;
        exp_en = !oe_n && m_sel && !wr_now();
        exp_d  = exp_en ? ref_mem[cur_ref()] : 32'h0;
        check(dout_en == exp_en && dout == exp_d, tag, {dout_en, dout[30:0]}, {exp_en, exp_d[30:0]});
        if (dout != exp_d) check(1'b0, tag, dout, exp_d);
    endtask

    // inputs were set after the falling edge; check, then clock the reference
    task automatic tick(input string tag);
        bit ld, ok;
        #1;
        model_check(tag);
        @(posedge clk);
        if (m_sel) begin
            for (int g = 0; g < 4; g++)
                if (!all_we_n || (!byte_we_n && !lane_we_n[g]))
                    ref_mem[cur_ref()][g*8 +: 8] = din[g*8 +: 8];
        end
        ld = !strobe_ctl_n || (!strobe_cpu_n && !sel_pipe_n);
        ok = !sel_pipe_n && sel_hi && !sel_lo_n;
        if (ld) begin
            m_sel = ok; m_base = addr[5:0]; m_cnt = 0; m_intlv = mode_intlv;
        end else if (m_sel && !adv_n) begin
            m_cnt = m_cnt + 1;
        end
        @(negedge clk);
    endtask

    // literal check of the current cycle with inputs unchanged
    task automatic expect_data(input logic [31:0] exp, input string tag);
        #1;
        check(dout_en && dout == exp, tag, dout, exp);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        idle();
        m_sel = 0; m_base = 0; m_cnt = 0; m_intlv = 0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(!dout_en && dout == 0, "R1 reset drive", dout, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!dout_en && dout == 0, "R1 after release", dout, 32'h0);

        // fill the reference region with global-write bursts (R8)
        for (int b = 0; b < REF_N / 4; b++) begin
            idle(); strobe_ctl_n = 0; addr = 10'(b * 4);
            tick("R2 fill load");
            for (int k = 0; k < 4; k++) begin
                idle(); all_we_n = 0; adv_n = 0; din = pat(b * 4 + k);
                tick("R8 fill write");
            end
        end

        // R10: processor strobe load, data in next cycle
        idle(); strobe_cpu_n = 0; addr = 10'd8;
        tick("R10 load");
        idle();
        expect_data(pat(8), "R10 first beat");
        // R3: gated processor strobe ignored
        idle(); strobe_cpu_n = 0; sel_pipe_n = 1; addr = 10'd40;
        tick("R3 gated cpu");
        idle();
        expect_data(pat(8), "R3 burst kept");
        // R3: controller load with bad select deselects
        idle(); strobe_ctl_n = 0; sel_hi = 0; addr = 10'd4;
        tick("R3 ctl deselect");
        idle(); #1;
        check(!dout_en && dout == 0, "R3 deselected", dout, 32'h0);

        // R4: linear from 13 -> 13 14 15 12 13
        idle(); strobe_ctl_n = 0; addr = 10'd13;
        tick("R4 load");
        begin
            int seq4 [5] = '{13, 14, 15, 12, 13};
            for (int k = 0; k < 5; k++) begin
                idle(); adv_n = 0;
                expect_data(pat(seq4[k]), "R4 linear beat");
                tick("R4 linear");
            end
        end

        // R5: interleaved from 22 -> 22 23 20 21, and from 45 -> 45 44 47 46
        idle(); strobe_ctl_n = 0; addr = 10'd22; mode_intlv = 1;
        tick("R5 load");
        begin
            int seq5 [4] = '{22, 23, 20, 21};
            for (int k = 0; k < 4; k++) begin
                idle(); adv_n = 0;
                expect_data(pat(seq5[k]), "R5 interleaved beat");
                tick("R5 interleaved");
            end
        end
        idle(); strobe_cpu_n = 0; addr = 10'd45; mode_intlv = 1;
        tick("R5 load b");
        begin
            int seq5b [4] = '{45, 44, 47, 46};
            for (int k = 0; k < 4; k++) begin
                idle(); adv_n = 0;
                expect_data(pat(seq5b[k]), "R5 interleaved start1");
                tick("R5 interleaved b");
            end
        end

        // R6: hold with advance high
        idle(); strobe_ctl_n = 0; addr = 10'd33;
        tick("R6 load");
        for (int k = 0; k < 3; k++) begin
            idle();
            expect_data(pat(33), "R6 hold");
            tick("R6 hold");
        end

        // R7: lane enables without qualifier do nothing
        idle(); strobe_ctl_n = 0; addr = 10'd30;
        tick("R7 load");
        idle(); lane_we_n = 4'h0; din = 32'hFFFF_FFFF;
        tick("R7 unqualified");
        idle();
        expect_data(pat(30), "R7 unqualified ignored");
        // R7: lane 1 only
        idle(); byte_we_n = 0; lane_we_n = 4'b1101; din = 32'h1122_3344;
        #1; check(!dout_en, "R9 off during write", {31'h0, dout_en}, 32'h0);
        tick("R7 lane1");
        idle();
        expect_data((pat(30) & 32'hFFFF_00FF) | 32'h0000_3300, "R7 lane1 merge");
        // R8: global write ignores lane enables
        idle(); all_we_n = 0; lane_we_n = 4'hF; din = 32'hDEAD_BEEF;
        tick("R8 global");
        idle();
        expect_data(32'hDEAD_BEEF, "R8 global written");
        // R9: output enable acts without a clock
        idle(); oe_n = 1; #1;
        check(!dout_en && dout == 0, "R9 oe high", dout, 32'h0);
        oe_n = 0; #0.5;
        check(dout_en && dout == 32'hDEAD_BEEF, "R9 oe low", dout, 32'hDEAD_BEEF);
        @(negedge clk);

        // mixed random run against the reference
        for (int i = 0; i < 4000; i++) begin
            int r, w;
            idle();
            r = $urandom % 8;
            addr = 10'($urandom % REF_N);
            mode_intlv = 1'($urandom % 2);
            sel_pipe_n = ($urandom % 6) == 0;
            sel_hi     = ($urandom % 8) != 0;
            sel_lo_n   = ($urandom % 8) == 0;
            if (r == 0) strobe_cpu_n = 0;
            if (r == 1) strobe_ctl_n = 0;
            adv_n = 1'($urandom % 2);
            w = $urandom % 4;
            if (w == 0) begin byte_we_n = 0; lane_we_n = 4'($urandom); end
            if (w == 1) begin all_we_n = 0; lane_we_n = 4'($urandom); end
            if (w == 2) lane_we_n = 4'($urandom);
            oe_n = ($urandom % 5) == 0;
            din = $urandom;
            tick("R2 R4 R5 R7 R8 R9 random");
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule